// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block drives a DMA data path from a table of scatter-gather descriptors held in system memory. Software writes the table base address, the block count and the block size, then pulses `start`. The walker fetches the descriptors one at a time through a simple word-read port. It checks each one and hands every data segment to a downstream data mover as an address and length request. When the final segment has been accepted it signals completion. If it finds a malformed table, or if the table disagrees with the programmed byte total, it stops and reports an error code to the interrupt logic.

Each descriptor occupies 64 bits. The low 32-bit word holds the attribute field in bits [15:0] and the byte length in bits [31:16]. The high word holds the 32-bit data address. A length of zero stands for the largest segment, 65536 bytes. A well-formed table gives every descriptor except the last the largest length, and the last carries the remainder.

Top module: `sg_desc_walker`

## Requirements
- R1: After reset, `busy`, `mrd_req`, `mv_req`, `xfer_done` and `err_pulse` are all 0, and `err_code` is 0.
- R2: On `start`, the table pointer loads from `table_base`. Descriptor n is fetched as two reads: first the low word at base+8n, then the high word at base+8n+4. Each read request holds its address until `mrd_ack` is returned, and the data is taken in the same cycle as the ack.
- R3: The low word holds attributes in bits [15:0] and length in bits [31:16]; the high word is the data address. In the attributes, bit 0 is valid, bit 1 is end, and bits [5:4] are the action code, where 2'b10 means transfer data.
- R4: A transfer descriptor produces one mover request. `mv_addr` equals the descriptor address and `mv_len` equals its byte length. The request is held stable until `mv_ack`.
- R5: A length field of 0 is issued as `mv_len` = 65536.
- R6: The expected byte total is `blk_count` times the block size, and a `blk_size` of 0 means 512 bytes.
- R7: A descriptor with the valid bit clear stops the walk with `err_code` 2'b01, and no mover request is issued for it.
- R8: A valid descriptor whose action code is not 2'b10 stops the walk with `err_code` 2'b10, and no mover request is issued for it.
- R9: The walk stops with `err_code` 2'b11 in three cases. The first is a length larger than the bytes still owed, and then no request is issued for that descriptor. The second is the total being used up after a descriptor without the end bit. The third is an end descriptor leaving bytes owed.
- R10: `xfer_done` pulses for one cycle only after `mv_ack` for the end descriptor, and only when the total is exactly used up. `busy` is low from the cycle after that, and `xfer_done` and `err_pulse` never pulse together.
- R11: A `start` pulse while `busy` is high is ignored, and the walk already in progress finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| table_base | input | 32 | Byte address of the first descriptor |
| blk_count | input | BCNT_W | Number of blocks in the transfer |
| blk_size | input | BSZ_W | Block size in bytes, 0 selects 512 |
| mrd_req | output | 1 | Descriptor word read request |
| mrd_addr | output | 32 | Descriptor word address |
| mrd_ack | input | 1 | Read accepted, data valid this cycle |
| mrd_data | input | 32 | Descriptor read data |
| mv_req | output | 1 | Data segment request to the mover |
| mv_addr | output | 32 | Segment start address |
| mv_len | output | 17 | Segment length in bytes (1..65536) |
| mv_ack | input | 1 | Segment accepted by the mover |
| busy | output | 1 | Walk in progress |
| xfer_done | output | 1 | One-cycle pulse on successful completion |
| err_pulse | output | 1 | One-cycle pulse when a walk aborts |
| err_code | output | 2 | Cause of the last abort, cleared by start |

## Verification
Some properties are checked by assertions on every cycle. Read and mover requests must stay stable while they wait for an ack. The high-word read must follow the low-word read at the next word address. The byte ledger must never be charged more than it still owes. Completion must come only right after an accepted segment, and can never coincide with an error. Other behaviour can only be shown by the bench's scenarios, because each depends on a whole table. These are the decoding of lengths and attributes, the three distinct abort causes and their codes, the 512-byte default, and the fact that a second start is ignored. The bench runs each table against a reference walk of the same memory contents and compares the resulting sequence of reads, segments and outcome.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

    localparam int WORD_W     = 32;
    localparam int SEG_W      = 17;
    localparam int SEG_MAX    = 65536;
    localparam int DESC_BYTES = 8;

    localparam int ATTR_VALID_BIT = 0;
    localparam int ATTR_END_BIT   = 1;
    localparam int ATTR_ACT_LO    = 4;
    localparam logic [1:0] ACT_XFER = 2'b10;

    typedef struct packed {
        logic [31:0] addr;
        logic [15:0] len;
        logic [15:0] attr;
    } sgw_desc_t;

    typedef struct packed {
        logic             valid;
        logic             last;
        logic             is_xfer;
        logic [SEG_W-1:0] bytes;
        logic [31:0]      addr;
    } sgw_seg_t;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'b00,
        ERR_INVALID = 2'b01,
        ERR_ACTION  = 2'b10,
        ERR_SIZE    = 2'b11
    } sgw_err_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_MOVE
    } sgw_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LO,
        PH_HI
    } sgw_phase_e;

    function automatic sgw_seg_t sgw_decode(input sgw_desc_t d);
        sgw_seg_t s;
        s.valid   = d.attr[ATTR_VALID_BIT];
        s.last    = d.attr[ATTR_END_BIT];
        s.is_xfer = (d.attr[ATTR_ACT_LO+1:ATTR_ACT_LO] == ACT_XFER);
        s.bytes   = (d.len == 16'd0) ? SEG_W'(SEG_MAX) : {1'b0, d.len};
        s.addr    = d.addr;
        return s;
    endfunction

endpackage

// File: rtl/sgw_desc_fetch.sv
module sgw_desc_fetch
    import sgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [31:0]       base,
    input  logic              go,
    input  logic              adv,
    output logic              mrd_req,
    output logic [31:0]       mrd_addr,
    input  logic              mrd_ack,
    input  logic [WORD_W-1:0] mrd_data,
    output sgw_desc_t         desc,
    output logic              desc_vld
);

    sgw_phase_e        phase;
    logic [31:0]       ptr;
    logic [WORD_W-1:0] lo_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            ptr      <= '0;
            lo_word  <= '0;
            desc     <= '0;
            desc_vld <= 1'b0;
        end else begin
            desc_vld <= 1'b0;
            if (load)
                ptr <= base;
            else if (adv)
                ptr <= ptr + 32'(DESC_BYTES);
            case (phase)
                PH_IDLE: if (go) phase <= PH_LO;
                PH_LO: if (mrd_ack) begin
                    lo_word <= mrd_data;
                    phase   <= PH_HI;
                end
                PH_HI: if (mrd_ack) begin
                    desc     <= {mrd_data, lo_word};
                    desc_vld <= 1'b1;
                    phase    <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign mrd_req  = (phase != PH_IDLE);
    assign mrd_addr = ptr + ((phase == PH_HI) ? 32'd4 : 32'd0);

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mrd_req && !mrd_ack) |=> (mrd_req && $stable(mrd_addr))); // R2

    AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (rst)
        (mrd_req && mrd_ack && phase == PH_LO) |=> (mrd_req && mrd_addr == $past(mrd_addr) + 32'd4)); // R2

endmodule

// File: rtl/sgw_byte_ledger.sv
module sgw_byte_ledger #(
    parameter int TOT_W = 28,
    parameter int AMT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TOT_W-1:0] total,
    input  logic             consume,
    input  logic [AMT_W-1:0] amount,
    output logic             fits,
    output logic             exact
);

    logic [TOT_W-1:0] owed;
    logic [TOT_W-1:0] amt_ext;

    assign amt_ext = TOT_W'(amount);
    assign fits    = (amt_ext <= owed);
    assign exact   = (amt_ext == owed);

    always_ff @(posedge clk) begin
        if (rst)
            owed <= '0;
        else if (load)
            owed <= total;
        else if (consume)
            owed <= owed - amt_ext;
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        consume |-> (amt_ext <= owed)); // R9

endmodule

// File: rtl/sg_desc_walker.sv
module sg_desc_walker
    import sgw_pkg::*;
#(
    parameter int BCNT_W  = 16,
    parameter int BSZ_W   = 12,
    parameter int DEF_BSZ = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [31:0]       table_base,
    input  logic [BCNT_W-1:0] blk_count,
    input  logic [BSZ_W-1:0]  blk_size,
    output logic              mrd_req,
    output logic [31:0]       mrd_addr,
    input  logic              mrd_ack,
    input  logic [31:0]       mrd_data,
    output logic              mv_req,
    output logic [31:0]       mv_addr,
    output logic [16:0]       mv_len,
    input  logic              mv_ack,
    output logic              busy,
    output logic              xfer_done,
    output logic              err_pulse,
    output logic [1:0]        err_code
);

    localparam int TOT_W = BCNT_W + BSZ_W;

    sgw_state_e       state;
    sgw_seg_t         cur;
    sgw_seg_t         dec;
    sgw_desc_t        f_desc;
    logic             f_vld;
    sgw_err_e         err_q;
    logic             done_q;
    logic             errp_q;

    logic             launch;
    logic             seg_ok;
    logic             go_next;
    logic             fits;
    logic             exact;
    logic [BSZ_W-1:0] eff_size;
    logic [TOT_W-1:0] total;

    assign launch   = (state == ST_IDLE) && start;
    assign seg_ok   = (state == ST_MOVE) && mv_ack;
    assign go_next  = seg_ok && !cur.last && !exact;
    assign eff_size = (blk_size == '0) ? BSZ_W'(DEF_BSZ) : blk_size;
    assign total    = TOT_W'(blk_count) * TOT_W'(eff_size);
    assign dec      = sgw_decode(f_desc);

    sgw_desc_fetch u_fetch (
        .clk      (clk),
        .rst      (rst),
        .load     (launch),
        .base     (table_base),
        .go       (launch || go_next),
        .adv      (go_next),
        .mrd_req  (mrd_req),
        .mrd_addr (mrd_addr),
        .mrd_ack  (mrd_ack),
        .mrd_data (mrd_data),
        .desc     (f_desc),
        .desc_vld (f_vld)
    );

    sgw_byte_ledger #(
        .TOT_W (TOT_W),
        .AMT_W (SEG_W)
    ) u_ledger (
        .clk     (clk),
        .rst     (rst),
        .load    (launch),
        .total   (total),
        .consume (seg_ok),
        .amount  ((state == ST_MOVE) ? cur.bytes : dec.bytes),
        .fits    (fits),
        .exact   (exact)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cur    <= '0;
            err_q  <= ERR_NONE;
            done_q <= 1'b0;
            errp_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            errp_q <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    err_q <= ERR_NONE;
                    state <= ST_FETCH;
                end
                ST_FETCH: if (f_vld) begin
                    if (!dec.valid) begin
                        err_q  <= ERR_INVALID;
                        errp_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (!dec.is_xfer) begin
                        err_q  <= ERR_ACTION;
                        errp_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (!fits) begin
                        err_q  <= ERR_SIZE;
                        errp_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        cur   <= dec;
                        state <= ST_MOVE;
                    end
                end
                ST_MOVE: if (mv_ack) begin
                    if (cur.last && exact) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (cur.last || exact) begin
                        err_q  <= ERR_SIZE;
                        errp_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        state <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mv_req    = (state == ST_MOVE);
    assign mv_addr   = cur.addr;
    assign mv_len    = cur.bytes;
    assign busy      = (state != ST_IDLE);
    assign xfer_done = done_q;
    assign err_pulse = errp_q;
    assign err_code  = err_q;

    AST_MV_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mv_req && !mv_ack) |=> (mv_req && $stable(mv_addr) && $stable(mv_len))); // R4

    AST_MV_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
        mv_req |-> (mv_len != '0 && mv_len <= 17'(SEG_MAX))); // R5

    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> $past(mv_req && mv_ack)); // R10

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        !(xfer_done && err_pulse)); // R10

    AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> (err_code != 2'b00 && !busy)); // R7

    AST_NO_MOVE_WHILE_FETCH: assert property (@(posedge clk) disable iff (rst)
        !(mv_req && mrd_req)); // R2

endmodule

// File: tb/sg_desc_walker_tb.sv
module sg_desc_walker_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] table_base = '0;
    logic [15:0] blk_count = '0;
    logic [11:0] blk_size = '0;
    logic        mrd_req;
    logic [31:0] mrd_addr;
    logic        mrd_ack = 1'b0;
    logic [31:0] mrd_data = '0;
    logic        mv_req;
    logic [31:0] mv_addr;
    logic [16:0] mv_len;
    logic        mv_ack = 1'b0;
    logic        busy;
    logic        xfer_done;
    logic        err_pulse;
    logic [1:0]  err_code;

    always #5 clk = ~clk;

    sg_desc_walker u_dut (
        .clk(clk), .rst(rst), .start(start), .table_base(table_base),
        .blk_count(blk_count), .blk_size(blk_size),
        .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_ack(mrd_ack), .mrd_data(mrd_data),
        .mv_req(mv_req), .mv_addr(mv_addr), .mv_len(mv_len), .mv_ack(mv_ack),
        .busy(busy), .xfer_done(xfer_done), .err_pulse(err_pulse), .err_code(err_code)
    );

    int checks = 0;
    int failures = 0;

    logic [31:0] mem [0:255];
    logic [31:0] rd_log[$];
    logic [31:0] mva_log[$];
    int          mvl_log[$];
    logic [31:0] exp_rd[$];
    logic [31:0] exp_mva[$];
    int          exp_mvl[$];
    int          rd_wait = 0;
    int          mv_wait = 0;
    bit          done_seen = 0;
    bit          err_seen = 0;
    int          err_val = 0;
    int          done_cnt = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Read port responder: one ack per request, random latency
    always @(negedge clk) begin
        if (rst) begin
            mrd_ack = 1'b0;
        end else if (mrd_ack) begin
            mrd_ack = 1'b0;
        end else if (mrd_req) begin
            if (rd_wait == 0) begin
                mrd_ack  = 1'b1;
                mrd_data = mem[mrd_addr[9:2]];
                rd_log.push_back(mrd_addr);
                rd_wait  = int'($urandom % 3);
            end else begin
                rd_wait--;
            end
        end
    end

    // Mover responder
    always @(negedge clk) begin
        if (rst) begin
            mv_ack = 1'b0;
        end else if (mv_ack) begin
            mv_ack = 1'b0;
        end else if (mv_req) begin
            if (mv_wait == 0) begin
                mv_ack = 1'b1;
                mva_log.push_back(mv_addr);
                mvl_log.push_back(int'(mv_len));
                mv_wait = int'($urandom % 4);
            end else begin
                mv_wait--;
            end
        end
    end

    // Outcome monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (xfer_done) begin done_seen = 1; done_cnt++; end
            if (err_pulse) begin err_seen = 1; err_val = int'(err_code); end
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = '0;
    endtask

    task automatic put_desc(input int n, input logic [15:0] attr,
                            input logic [15:0] len, input logic [31:0] addr);
        mem[(2*n) & 255]     = {len, attr};
        mem[(2*n + 1) & 255] = addr;
    endtask

    // Well-formed table: full segments then remainder, last marked end
    task automatic build_good(input longint total, input logic [31:0] dbase);
        int n;
        longint bytes;
        n = int'((total + 65535) / 65536);
        for (int i = 0; i < n; i++) begin
            bytes = (i < n - 1) ? 65536 : total - 65536 * longint'(n - 1);
            put_desc(i, (i == n - 1) ? 16'h0023 : 16'h0021, bytes[15:0],
                     dbase + 32'(i) * 32'h0001_0000);
        end
    endtask

    // Reference walk over the bench memory; returns outcome code (0 = done)
    function automatic int ref_walk(input logic [31:0] base, input longint total);
        longint owed = total;
        logic [31:0] lo, hi, a;
        longint bytes;
        exp_rd.delete(); exp_mva.delete(); exp_mvl.delete();
        for (int i = 0; i < 128; i++) begin
            a  = base + 32'(8 * i);
            lo = mem[a[9:2]];
            hi = mem[(a[9:2] + 8'd1)];
            exp_rd.push_back(a);
            exp_rd.push_back(a + 32'd4);
            bytes = (lo[31:16] == 16'd0) ? 65536 : longint'(lo[31:16]);
            if (!lo[0]) return 1;
            if (lo[5:4] != 2'b10) return 2;
            if (bytes > owed) return 3;
            exp_mva.push_back(hi);
            exp_mvl.push_back(int'(bytes));
            owed -= bytes;
            if (lo[1]) return (owed == 0) ? 0 : 3;
            if (owed == 0) return 3;
        end
        return 3;
    endfunction

    task automatic run_case(input string tag, input logic [31:0] base,
                            input logic [15:0] cnt, input logic [11:0] size,
                            input bit restart_mid);
        longint total;
        int exp_code;
        int got_code;
        bit ok;
        int wd;
        total = longint'(cnt) * ((size == 0) ? 512 : longint'(size));
        exp_code = ref_walk(base, total);
        rd_log.delete(); mva_log.delete(); mvl_log.delete();
        done_seen = 0; err_seen = 0; err_val = 0;
        @(negedge clk);
        table_base = base; blk_count = cnt; blk_size = size; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (restart_mid) begin
            repeat (3) @(negedge clk);
            table_base = base + 32'h0000_0100; blk_count = 16'd1; blk_size = 12'd1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wd = 0;
        while (!done_seen && !err_seen && wd < 5000) begin
            @(negedge clk);
            wd++;
        end
        @(negedge clk);
        got_code = done_seen ? 0 : (err_seen ? err_val : -1);
        chk(got_code == exp_code, tag, "outcome code", got_code, exp_code);
        chk(!busy, "R10", "busy after outcome", busy, 0);
        ok = (mva_log.size() == exp_mva.size());
        if (ok) for (int i = 0; i < exp_mva.size(); i++)
            if (mva_log[i] != exp_mva[i] || mvl_log[i] != exp_mvl[i]) ok = 0;
        chk(ok, "R4", {tag, " segment list"}, mva_log.size(), exp_mva.size());
        ok = (rd_log.size() == exp_rd.size());
        if (ok) for (int i = 0; i < exp_rd.size(); i++)
            if (rd_log[i] != exp_rd[i]) ok = 0;
        chk(ok, "R2", {tag, " read order"}, rd_log.size(), exp_rd.size());
    endtask

    initial begin
        int dummy;
        longint tot;
        logic [15:0] rc;
        logic [11:0] rs;
        dummy = int'($urandom(32'h5EED_0042));
        clear_mem();
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!busy && !mrd_req && !mv_req, "R1", "idle outputs", {busy, mrd_req, mv_req}, 0);
        chk(!xfer_done && !err_pulse && err_code == 2'b00, "R1", "pulse outputs",
            {xfer_done, err_pulse, err_code}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !mrd_req, "R1", "idle after release", {busy, mrd_req}, 0);

        // R6/R3/R10: one end descriptor, default block size 4x512
        clear_mem();
        put_desc(0, 16'h0023, 16'd2048, 32'h8000_0000);
        run_case("R6", 32'h0000_1000, 16'd4, 12'd0, 1'b0);
        chk(mva_log.size() == 1 && mvl_log[0] == 2048, "R6", "default size total", mvl_log.size(), 1);
        chk(done_cnt == 1, "R10", "single done pulse", done_cnt, 1);

        // R5: zero length field means 65536
        clear_mem();
        build_good(300 * 512, 32'h4000_0000);
        run_case("R5", 32'h0000_1000, 16'd300, 12'd512, 1'b0);
        chk(mvl_log.size() == 3 && mvl_log[0] == 65536, "R5", "zero length decode",
            (mvl_log.size() > 0) ? mvl_log[0] : -1, 65536);

        // R11: start while busy ignored
        run_case("R11", 32'h0000_1000, 16'd300, 12'd512, 1'b1);

        // R7: valid bit clear on second descriptor
        clear_mem();
        put_desc(0, 16'h0021, 16'd512, 32'h1111_0000);
        put_desc(1, 16'h0022, 16'd512, 32'h2222_0000);
        run_case("R7", 32'h0000_1000, 16'd2, 12'd512, 1'b0);

        // R8: action code 01
        clear_mem();
        put_desc(0, 16'h0013, 16'd512, 32'h3333_0000);
        run_case("R8", 32'h0000_1000, 16'd1, 12'd512, 1'b0);
        chk(mva_log.size() == 0, "R8", "no segment issued", mva_log.size(), 0);

        // R9: length larger than owed
        clear_mem();
        put_desc(0, 16'h0023, 16'd1024, 32'h5555_0000);
        run_case("R9", 32'h0000_1000, 16'd1, 12'd512, 1'b0);
        chk(mva_log.size() == 0, "R9", "oversize not issued", mva_log.size(), 0);

        // R9: total used up before end
        clear_mem();
        put_desc(0, 16'h0021, 16'd512, 32'h6666_0000);
        run_case("R9", 32'h0000_1000, 16'd1, 12'd512, 1'b0);

        // R9: end leaves bytes owed
        clear_mem();
        put_desc(0, 16'h0023, 16'd512, 32'h7777_0000);
        run_case("R9", 32'h0000_1000, 16'd2, 12'd512, 1'b0);
        chk(err_code == 2'b11, "R9", "code held after abort", err_code, 3);

        // Random well-formed tables
        for (int k = 0; k < 16; k++) begin
            rc = 16'(1 + ($urandom % 400));
            rs = ($urandom % 3 == 0) ? 12'd0 : 12'(1 + ($urandom % 4095));
            tot = longint'(rc) * ((rs == 0) ? 512 : longint'(rs));
            clear_mem();
            build_good(tot, 32'($urandom) & 32'hFFFF_0000);
            run_case("R4", 32'h0000_0800, rc, rs, 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule